// File: doc/BRIEF.md
# SPI Command Receive Front-End with Opcode Filter

This block sits behind the pins of a serial peripheral slave in SPI mode 0. It decodes the start of a command and filters its first byte. Two active-low chip selects are accepted, and either one may open a transaction. While exactly one of them is low, bits on MOSI are taken MSB first on each rising SCK edge. SCK, both selects and MOSI are first brought into the system clock domain through flop synchronisers, and SCK edges are then found by comparing successive synchronised samples.

The first byte of a transaction is the command code. If it is in the parameter list of accepted codes, the block announces it with a one-cycle start strobe. Every later complete byte goes out as a one-cycle data strobe, and an end strobe follows when the selects return high. If the code is not in the list, the block stays completely quiet until both selects have gone high and a new select falling edge arrives. Bits of an unfinished byte are thrown away when the select rises. All outputs are registered, and a downstream command handler consumes the stream.

Top module: `spi_cmd_frontend`

## Requirements
- R1: While reset is high and in the first cycle after it, opcode_valid, byte_valid and txn_end are 0, and opcode and byte_data are 0.
- R2: After a single chip select falls, the first 8 MOSI bits, taken MSB first on rising SCK edges, form the command code. If the code is accepted, opcode_valid pulses for one cycle with opcode holding the code, no later than three clock cycles after the SCK edge of its eighth bit reaches the pin.
- R3: After an accepted code, each further group of 8 bits gives a one-cycle byte_valid pulse with byte_data holding that byte, MSB first. opcode_valid and byte_valid never pulse together.
- R4: After a code that is not accepted, opcode_valid, byte_valid and txn_end all stay 0 until both selects have been high and a new transaction has started.
- R5: Bits of an incomplete byte are dropped when the selects return high, with no byte_valid for them, and the next transaction counts bits from zero.
- R6: When both selects return high after an accepted code, txn_end pulses once for one cycle.
- R7: A transaction can be started through cs0_n alone or through cs1_n alone.
- R8: If both selects are low at once, that transaction produces no output strobes until both are high again.
- R9: SCK edges while both selects are high have no effect on any output or on the next transaction.
- R10: The accepted code set is a parameter list, by default 0x03, 0x02, 0x06, 0x20 and 0x05. The code 0x9F, for example, is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock from the master (asynchronous) |
| cs0_n | input | 1 | First active-low chip select |
| cs1_n | input | 1 | Second active-low chip select |
| mosi | input | 1 | Serial data from the master |
| opcode_valid | output | 1 | One-cycle strobe: accepted command code |
| opcode | output | BYTE_W | Last accepted command code |
| byte_valid | output | 1 | One-cycle strobe: complete data byte |
| byte_data | output | BYTE_W | Last complete data byte |
| txn_end | output | 1 | One-cycle strobe: transaction with accepted code ended |

## Verification
A bit counter that is out of step shows up on byte_data, shifted by one or more bit positions, or as a missing or extra byte_valid within eight SCK edges. It is most visible in the first transaction after a truncated one. If the mute or idle state is wrong, strobes appear during a rejected transaction, a dual-select transaction or an unselected SCK burst, or txn_end is missing, and this shows within three clock cycles of the event that caused it. The bench's reference model predicts every output every cycle, so a divergence is reported in the cycle it occurs.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;
  typedef enum logic [1:0] {
    FE_IDLE   = 2'd0,
    FE_OPCODE = 2'd1,
    FE_DATA   = 2'd2,
    FE_MUTE   = 2'd3
  } fe_state_t;

  localparam int SEL_W = 2;

  function automatic logic sel_none(input logic [SEL_W-1:0] s);
    return &s;
  endfunction

  function automatic logic sel_both(input logic [SEL_W-1:0] s);
    return ~|s;
  endfunction

  function automatic logic sel_single(input logic [SEL_W-1:0] s);
    return ^s;
  endfunction
endpackage

// File: rtl/spi_fe_sync.sv
module spi_fe_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  generate
    if (STAGES <= 1) begin : g_single
      logic [WIDTH-1:0] stage;
      always_ff @(posedge clk) begin
        if (rst) stage <= RESET_VAL;
        else     stage <= d;
      end
      assign q = stage;
    end else begin : g_chain
      logic [STAGES-1:0][WIDTH-1:0] stage;
      always_ff @(posedge clk) begin
        if (rst) stage <= {STAGES{RESET_VAL}};
        else     stage <= {stage[STAGES-2:0], d};
      end
      assign q = stage[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/spi_fe_opmatch.sv
module spi_fe_opmatch #(
  parameter int BYTE_W = 8,
  parameter int NUM_OPS = 5,
  parameter logic [NUM_OPS*BYTE_W-1:0] OP_LIST = {8'h03, 8'h02, 8'h06, 8'h20, 8'h05}
) (
  input  logic [BYTE_W-1:0] code,
  output logic              hit
);
  logic [NUM_OPS-1:0] hit_vec;

  generate
    for (genvar g = 0; g < NUM_OPS; g++) begin : g_cmp
      assign hit_vec[g] = (code == OP_LIST[g*BYTE_W +: BYTE_W]);
    end
  endgenerate

  assign hit = |hit_vec;
endmodule

// File: rtl/spi_fe_shifter.sv
module spi_fe_shifter #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic              byte_done,
  output logic [BYTE_W-1:0] byte_next
);
  localparam int CNT_W = (BYTE_W > 2) ? $clog2(BYTE_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-2:0] partial;

  assign byte_next = {partial, bit_in};
  assign byte_done = shift_en && (bit_cnt == LAST_BIT);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      bit_cnt <= '0;
      partial <= '0;
    end else if (shift_en) begin
      partial <= byte_next[BYTE_W-2:0];
      bit_cnt <= byte_done ? '0 : bit_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/spi_cmd_frontend.sv
module spi_cmd_frontend
  import spi_fe_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int NUM_OPS = 5,
  parameter int SYNC_STAGES = 2,
  parameter logic [NUM_OPS*BYTE_W-1:0] OP_LIST = {8'h03, 8'h02, 8'h06, 8'h20, 8'h05}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck,
  input  logic              cs0_n,
  input  logic              cs1_n,
  input  logic              mosi,
  output logic              opcode_valid,
  output logic [BYTE_W-1:0] opcode,
  output logic              byte_valid,
  output logic [BYTE_W-1:0] byte_data,
  output logic              txn_end
);
  localparam int PIN_W = 2 + SEL_W;

  logic [PIN_W-1:0] pins_s;
  logic             sck_s, sck_q, mosi_s, sck_rise;
  logic [SEL_W-1:0] sel_s, sel_start;
  fe_state_t        state;
  logic             in_txn, shift_en, clear_bits, byte_done, code_hit;
  logic [BYTE_W-1:0] byte_next;

  spi_fe_sync #(
    .WIDTH(PIN_W), .STAGES(SYNC_STAGES), .RESET_VAL({1'b0, 2'b11, 1'b0})
  ) u_sync (
    .clk(clk), .rst(rst), .d({sck, cs1_n, cs0_n, mosi}), .q(pins_s)
  );

  assign sck_s  = pins_s[PIN_W-1];
  assign sel_s  = pins_s[SEL_W:1];
  assign mosi_s = pins_s[0];

  always_ff @(posedge clk) begin
    if (rst) sck_q <= 1'b0;
    else     sck_q <= sck_s;
  end

  assign sck_rise   = sck_s && !sck_q;
  assign in_txn     = (state == FE_OPCODE) || (state == FE_DATA);
  assign shift_en   = sck_rise && in_txn && (sel_s == sel_start);
  assign clear_bits = !in_txn;

  spi_fe_shifter #(.BYTE_W(BYTE_W)) u_shift (
    .clk(clk), .rst(rst), .clear(clear_bits), .shift_en(shift_en),
    .bit_in(mosi_s), .byte_done(byte_done), .byte_next(byte_next)
  );

  spi_fe_opmatch #(.BYTE_W(BYTE_W), .NUM_OPS(NUM_OPS), .OP_LIST(OP_LIST)) u_match (
    .code(byte_next), .hit(code_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= FE_IDLE;
      sel_start    <= '1;
      opcode_valid <= 1'b0;
      opcode       <= '0;
      byte_valid   <= 1'b0;
      byte_data    <= '0;
      txn_end      <= 1'b0;
    end else begin
      opcode_valid <= 1'b0;
      byte_valid   <= 1'b0;
      txn_end      <= 1'b0;
      unique case (state)
        FE_IDLE: begin
          if (sel_single(sel_s)) begin
            state     <= FE_OPCODE;
            sel_start <= sel_s;
          end else if (sel_both(sel_s)) begin
            state <= FE_MUTE;
          end
        end
        FE_OPCODE, FE_DATA: begin
          if (sel_none(sel_s)) begin
            state   <= FE_IDLE;
            txn_end <= (state == FE_DATA);
          end else if (sel_s != sel_start) begin
            state <= FE_MUTE;
          end else if (byte_done) begin
            if (state == FE_DATA) begin
              byte_valid <= 1'b1;
              byte_data  <= byte_next;
            end else if (code_hit) begin
              opcode_valid <= 1'b1;
              opcode       <= byte_next;
              state        <= FE_DATA;
            end else begin
              state <= FE_MUTE;
            end
          end
        end
        FE_MUTE: begin
          if (sel_none(sel_s)) state <= FE_IDLE;
        end
        default: state <= FE_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_fe_chk.sv
module spi_fe_chk #(
  parameter int BYTE_W = 8,
  parameter int NUM_OPS = 5,
  parameter logic [NUM_OPS*BYTE_W-1:0] OP_LIST = {8'h03, 8'h02, 8'h06, 8'h20, 8'h05}
) (
  input logic              clk,
  input logic              rst,
  input logic              opcode_valid,
  input logic [BYTE_W-1:0] opcode,
  input logic              byte_valid,
  input logic [BYTE_W-1:0] byte_data,
  input logic              txn_end
);
  logic open_cmd;

  always_ff @(posedge clk) begin
    if (rst)               open_cmd <= 1'b0;
    else if (opcode_valid) open_cmd <= 1'b1;
    else if (txn_end)      open_cmd <= 1'b0;
  end

  function automatic logic listed(input logic [BYTE_W-1:0] c);
    logic r;
    r = 1'b0;
    for (int i = 0; i < NUM_OPS; i++)
      if (OP_LIST[i*BYTE_W +: BYTE_W] == c) r = 1'b1;
    return r;
  endfunction

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!opcode_valid && !byte_valid && !txn_end && opcode == '0 && byte_data == '0));

  // R2
  opcode_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    opcode_valid |=> !opcode_valid);

  // R3
  byte_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    byte_valid |=> !byte_valid);

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(opcode_valid && byte_valid));

  // R4
  byte_after_code_chk: assert property (@(posedge clk) disable iff (rst)
    byte_valid |-> open_cmd);

  // R6
  end_after_code_chk: assert property (@(posedge clk) disable iff (rst)
    txn_end |-> (open_cmd && !opcode_valid && !byte_valid));

  // R10
  code_listed_chk: assert property (@(posedge clk) disable iff (rst)
    opcode_valid |-> listed(opcode));
endmodule

bind spi_cmd_frontend spi_fe_chk #(
  .BYTE_W(BYTE_W), .NUM_OPS(NUM_OPS), .OP_LIST(OP_LIST)
) u_chk (
  .clk(clk), .rst(rst), .opcode_valid(opcode_valid), .opcode(opcode),
  .byte_valid(byte_valid), .byte_data(byte_data), .txn_end(txn_end)
);

// File: tb/spi_cmd_frontend_bench.sv
module spi_cmd_frontend_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck = 1'b0, cs0_n = 1'b1, cs1_n = 1'b1, mosi = 1'b0;
  logic       opcode_valid, byte_valid, txn_end;
  logic [7:0] opcode, byte_data;

  int checks = 0;
  int bad = 0;
  int cycles = 0;

  spi_cmd_frontend u_spi_cmd_frontend (
    .clk(clk), .rst(rst), .sck(sck), .cs0_n(cs0_n), .cs1_n(cs1_n), .mosi(mosi),
    .opcode_valid(opcode_valid), .opcode(opcode), .byte_valid(byte_valid),
    .byte_data(byte_data), .txn_end(txn_end)
  );

  always #2 clk = ~clk;

  function automatic bit accepted(input logic [7:0] c);
    return c == 8'h03 || c == 8'h02 || c == 8'h06 || c == 8'h20 || c == 8'h05;
  endfunction

  // Reference model: pins as seen after the synchroniser delay
  logic [3:0] hist[$];
  int   m_mode = 0;
  int   m_bits = 0;
  int   m_acc = 0;
  logic [1:0] m_pat = 2'b11;
  logic e_ov = 0, e_bv = 0, e_te = 0;
  logic [7:0] e_op = 0, e_bd = 0;

  always @(posedge clk) begin
    logic [3:0] cur, prv;
    logic [1:0] cs;
    logic rise;
    e_ov = 0; e_bv = 0; e_te = 0;
    if (rst) begin
      hist.delete();
      repeat (4) hist.push_front(4'b0110);
      m_mode = 0; m_bits = 0; m_acc = 0; m_pat = 2'b11; e_op = 0; e_bd = 0;
    end else begin
      hist.push_front({sck, cs1_n, cs0_n, mosi});
      cur = hist[2];
      prv = hist[3];
      void'(hist.pop_back());
      cs = cur[2:1];
      rise = cur[3] && !prv[3];
      if (m_mode == 0) begin
        m_bits = 0; m_acc = 0;
        if (cs == 2'b01 || cs == 2'b10) begin m_mode = 1; m_pat = cs; end
        else if (cs == 2'b00) m_mode = 3;
      end else if (m_mode == 3) begin
        if (cs == 2'b11) m_mode = 0;
      end else begin
        if (cs == 2'b11) begin e_te = (m_mode == 2); m_mode = 0; end
        else if (cs != m_pat) m_mode = 3;
        else if (rise) begin
          m_acc = ((m_acc << 1) | int'(cur[0])) & 255;
          m_bits++;
          if (m_bits == 8) begin
            m_bits = 0;
            if (m_mode == 2) begin e_bv = 1; e_bd = m_acc[7:0]; end
            else if (accepted(m_acc[7:0])) begin e_ov = 1; e_op = m_acc[7:0]; m_mode = 2; end
            else m_mode = 3;
            m_acc = 0;
          end
        end
      end
    end
  end

  // Event monitor for directed checks
  int n_ov = 0, n_bv = 0, n_te = 0;
  logic [7:0] last_op = 0;
  logic [7:0] got_bytes[$];

  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      checks++;
      if (opcode_valid !== e_ov || (opcode !== e_op)) begin
        bad++;
        $display("FAIL R2 model: opcode_valid/opcode=%0b/%h expected %0b/%h", opcode_valid, opcode, e_ov, e_op);
      end else if (byte_valid !== e_bv || (byte_data !== e_bd)) begin
        bad++;
        $display("FAIL R3 model: byte_valid/byte_data=%0b/%h expected %0b/%h", byte_valid, byte_data, e_bv, e_bd);
      end else if (txn_end !== e_te) begin
        bad++;
        $display("FAIL R6 model: txn_end=%0b expected %0b", txn_end, e_te);
      end
      if (opcode_valid) begin n_ov++; last_op = opcode; end
      if (byte_valid) begin n_bv++; got_bytes.push_back(byte_data); end
      if (txn_end) n_te++;
    end
  end

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_mon();
    n_ov = 0; n_bv = 0; n_te = 0; got_bytes.delete();
  endtask

  task automatic spi_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      @(negedge clk); mosi = b[i];
      repeat (4) @(negedge clk); sck = 1'b1;
      repeat (4) @(negedge clk); sck = 1'b0;
    end
  endtask

  task automatic cs_on(input logic [1:0] pat);
    @(negedge clk); {cs1_n, cs0_n} = pat;
    repeat (6) @(negedge clk);
  endtask

  task automatic cs_off();
    repeat (6) @(negedge clk); cs0_n = 1'b1; cs1_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    // R1 reset state
    check_eq("R1", "strobes in reset", {opcode_valid, byte_valid, txn_end}, 0);
    check_eq("R1", "values in reset", {opcode, byte_data}, 0);
    @(negedge clk); rst = 1'b0;
    repeat (3) @(negedge clk);

    // R2 R3 R6 R7: accepted code via cs0_n with two data bytes
    clear_mon();
    cs_on(2'b10); spi_bits(8'h03, 8); spi_bits(8'hA5, 8); spi_bits(8'h3C, 8); cs_off();
    check_eq("R2", "code strobes", n_ov, 1);
    check_eq("R2", "code value", last_op, 8'h03);
    check_eq("R3", "byte strobes", n_bv, 2);
    if (got_bytes.size() == 2) begin
      check_eq("R3", "first byte", got_bytes[0], 8'hA5);
      check_eq("R3", "second byte", got_bytes[1], 8'h3C);
    end
    check_eq("R6", "end strobes", n_te, 1);

    // R7: code only, via cs1_n
    clear_mon();
    cs_on(2'b01); spi_bits(8'h06, 8); cs_off();
    check_eq("R7", "cs1 code strobes", n_ov, 1);
    check_eq("R7", "cs1 code value", last_op, 8'h06);
    check_eq("R6", "cs1 end strobes", n_te, 1);

    // R4 R10: unknown code 0x9F, then data
    clear_mon();
    cs_on(2'b10); spi_bits(8'h9F, 8); spi_bits(8'h03, 8); spi_bits(8'h55, 8); cs_off();
    check_eq("R4", "muted strobes", n_ov + n_bv + n_te, 0);

    // R5: partial byte dropped, counter restarts next transaction
    clear_mon();
    cs_on(2'b10); spi_bits(8'h02, 8); spi_bits(8'hC3, 8); spi_bits(8'hFF, 5); cs_off();
    check_eq("R5", "bytes with partial", n_bv, 1);
    check_eq("R6", "end after partial", n_te, 1);
    clear_mon();
    cs_on(2'b01); spi_bits(8'h05, 8); spi_bits(8'h81, 8); cs_off();
    check_eq("R5", "code after partial", last_op, 8'h05);
    check_eq("R5", "byte count after partial", n_bv, 1);
    if (got_bytes.size() == 1) check_eq("R5", "byte after partial", got_bytes[0], 8'h81);

    // R8: both selects low
    clear_mon();
    cs_on(2'b00); spi_bits(8'h03, 8); spi_bits(8'h12, 8); cs_off();
    check_eq("R8", "dual select strobes", n_ov + n_bv + n_te, 0);

    // R9: SCK activity without select, then a clean transaction
    clear_mon();
    spi_bits(8'hFF, 8); spi_bits(8'h20, 5);
    repeat (8) @(negedge clk);
    check_eq("R9", "unselected strobes", n_ov + n_bv + n_te, 0);
    cs_on(2'b10); spi_bits(8'h20, 8); spi_bits(8'h7E, 8); cs_off();
    check_eq("R9", "code after idle clocks", last_op, 8'h20);
    check_eq("R10", "listed code strobes", n_ov, 1);
    if (got_bytes.size() == 1) check_eq("R9", "byte after idle clocks", got_bytes[0], 8'h7E);

    finish_run();
  end

  initial begin
    wait (cycles > 150000);
    bad++; checks++;
    $display("FAIL watchdog: cycles=%0d expected below 150000", cycles);
    finish_run();
  end
endmodule